// File: doc/BRIEF.md
# Byte-Wide Memory Enable Decoder

This block sits between a processor's memory-access port and an external byte-wide bus. Each access presents a 17-bit physical address, which covers 128 KB. The block turns that address into active-low chip enables for the static RAMs, active-low enables for memory-mapped peripherals, and a write strobe. It also drives the low 15 address bits straight onto the bus address lines, with no multiplexing. A partition input, counted in 2 KB granules, splits the space into two parts. Addresses below the boundary hold program code and cannot be written. Addresses at or above the boundary are data.

A strap input selects the memory arrangement.

- **Four 32 KB devices.** Each of the four chip enables owns one quarter of the space.
- **One 128 KB device.** The first enable becomes the device's only chip enable. The second and third enables carry the two top address bits, and the fourth is parked high.

When the peripheral-select input is set, data accesses leave the memories and go to four 16 KB peripheral enables, chosen by address bits 15:14. A power-fail input keeps the battery-backed enables inactive.

All outputs are registered. Inputs are sampled on the rising clock edge at which the access strobe is high, and the result appears after that edge. When no access is in progress, every enable and the write strobe sit high.

Top module: `bwmem_decoder`

## Requirements
- R1: During reset, and in the cycle after any edge where `acc_en` was low, `ce_n`, `pe_n` and `wr_n` are all ones.
- R2: With `msel_wide`=1, an access that goes to memory drives `ce_n[k]` low, where k = `acc_addr[16:15]` (bit 0 is the first enable). All other `ce_n` bits stay high.
- R3: With `msel_wide`=0, a memory access drives `ce_n[0]` low. `ce_n[1]` carries `acc_addr[16]`, `ce_n[2]` carries `acc_addr[15]`, and `ce_n[3]` stays high.
- R4: With `per_sel`=1, a data access (`acc_addr` >= `part_bound`*2048) drives `pe_n[j]` low, where j = `acc_addr[15:14]`. All `ce_n` bits stay high.
- R5: With `per_sel`=0, `pe_n` stays all ones. A program access (`acc_addr` < `part_bound`*2048) goes to memory even when `per_sel`=1.
- R6: `wr_n` goes low only for an access with `acc_wr`=1 whose address is in data space. Writes to program space leave `wr_n` high.
- R7: While `pwr_fail`=1 at the sampling edge, all four `ce_n` bits and `pe_n[1:0]` stay high. `pe_n[3:2]` still decode normally.
- R8: At most one of the enables is low per access. In the 32 KB arrangement these are the four chip enables and the four peripheral enables. In the 128 KB arrangement they are `ce_n[0]` and the four peripheral enables.
- R9: The results of an access appear exactly one clock edge after the edge that samples it. `ba` then equals `acc_addr[14:0]`.
- R10: `part_bound`=0 makes every address data space. `part_bound`=64 makes every address program space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe; inputs are sampled while it is high |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | 17 | Physical byte address |
| part_bound | input | 7 | Program/data boundary in 2 KB granules (0..64) |
| per_sel | input | 1 | Route data accesses to peripheral enables |
| msel_wide | input | 1 | Strap: 1 = four 32 KB devices, 0 = one 128 KB device |
| pwr_fail | input | 1 | Supply below threshold; gates battery-backed enables |
| ba | output | 15 | Registered bus address, low 15 bits |
| ce_n | output | 4 | Active-low memory chip enables (128 KB arrangement: high address lines on bits 1 and 2) |
| pe_n | output | 4 | Active-low peripheral enables, 16 KB each |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Every result of this block is due one edge after the rising edge that samples an access: the enables, the write strobe and the bus address. The bench drives inputs on the falling edge, so the next rising edge captures them. It compares the outputs on the falling edge after that. A directed test also checks, a quarter period after drive, that the outputs have not yet moved. The idle case is checked the same way: one edge after a cycle with the strobe low, every enable must read high. All assertions use a one-cycle implication to match this latency.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // Where an access is steered.
  typedef enum logic [1:0] {
    RT_NONE   = 2'd0,
    RT_SRAM   = 2'd1,
    RT_PERIPH = 2'd2
  } route_e;

  // A granule index lies in program space when it is below the boundary.
  function automatic logic gran_below(input int unsigned gran, input int unsigned bound);
    return gran < bound;
  endfunction

endpackage

// File: rtl/bwm_classify.sv
module bwm_classify
  import bwm_pkg::*;
#(
  parameter int GIDX_W  = 6,
  parameter int BOUND_W = 7
) (
  input  logic               en,
  input  logic               per_sel,
  input  logic [GIDX_W-1:0]  gran_idx,
  input  logic [BOUND_W-1:0] bound,
  output logic               is_prog,
  output route_e             route
);

  always_comb begin
    is_prog = gran_below(int'(gran_idx), int'(bound));
    if (!en)
      route = RT_NONE;
    else if (per_sel && !is_prog)
      route = RT_PERIPH;
    else
      route = RT_SRAM;
  end

endmodule

// File: rtl/bwm_sram_map.sv
module bwm_sram_map #(
  parameter int NUM_CE = 4,
  parameter int HI_W   = 2
) (
  input  logic              sel,
  input  logic              wide,
  input  logic [HI_W-1:0]   hi_addr,
  output logic [NUM_CE-1:0] ce_n
);

  for (genvar k = 0; k < NUM_CE; k++) begin : g_ce
    logic wide_n;
    logic narrow_n;
    assign wide_n = !(sel && (hi_addr == HI_W'(k)));
    if (k == 0) begin : g_primary
      assign narrow_n = !sel;
    end else if (k <= HI_W) begin : g_addr_line
      // Enable k carries the address bit that is k places below the top.
      assign narrow_n = sel ? hi_addr[HI_W-k] : 1'b1;
    end else begin : g_parked
      assign narrow_n = 1'b1;
    end
    assign ce_n[k] = wide ? wide_n : narrow_n;
  end

endmodule

// File: rtl/bwm_pe_map.sv
module bwm_pe_map #(
  parameter int NUM_PE = 4,
  parameter int PSEL_W = 2
) (
  input  logic              hit,
  input  logic [PSEL_W-1:0] slot,
  output logic [NUM_PE-1:0] pe_n
);

  for (genvar j = 0; j < NUM_PE; j++) begin : g_pe
    assign pe_n[j] = !(hit && (slot == PSEL_W'(j)));
  end

endmodule

// File: rtl/bwm_pf_gate.sv
module bwm_pf_gate #(
  parameter int         N    = 4,
  parameter logic [N-1:0] MASK = '1
) (
  input  logic         pf,
  input  logic [N-1:0] in_n,
  output logic [N-1:0] out_n
);

  for (genvar i = 0; i < N; i++) begin : g_gate
    if (MASK[i]) begin : g_backed
      assign out_n[i] = in_n[i] | pf;
    end else begin : g_plain
      assign out_n[i] = in_n[i];
    end
  end

endmodule

// File: rtl/bwmem_decoder.sv
module bwmem_decoder
  import bwm_pkg::*;
#(
  parameter int              ADDR_W     = 17,
  parameter int              BLK_W      = 15,
  parameter int              GRAN_W     = 11,
  parameter int              PE_W       = 14,
  parameter int              NUM_CE     = 4,
  parameter int              NUM_PE     = 4,
  parameter logic [NUM_CE-1:0] CE_PF_MASK = 4'b1111,
  parameter logic [NUM_PE-1:0] PE_PF_MASK = 4'b0011
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_en,
  input  logic                       acc_wr,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic [ADDR_W-GRAN_W:0]     part_bound,
  input  logic                       per_sel,
  input  logic                       msel_wide,
  input  logic                       pwr_fail,
  output logic [BLK_W-1:0]           ba,
  output logic [NUM_CE-1:0]          ce_n,
  output logic [NUM_PE-1:0]          pe_n,
  output logic                       wr_n
);

  localparam int BOUND_W = ADDR_W - GRAN_W + 1;
  localparam int GIDX_W  = ADDR_W - GRAN_W;
  localparam int HI_W    = ADDR_W - BLK_W;
  localparam int PSEL_W  = $clog2(NUM_PE);

  // Named internal events, observed by the bound checker.
  logic              cls_is_prog;
  route_e            cls_route;
  logic              sram_sel;
  logic              pe_hit;
  logic [NUM_CE-1:0] ce_map_n;
  logic [NUM_PE-1:0] pe_map_n;
  logic [NUM_CE-1:0] ce_nxt_n;
  logic [NUM_PE-1:0] pe_nxt_n;
  logic              wr_nxt_n;

  bwm_classify #(.GIDX_W(GIDX_W), .BOUND_W(BOUND_W)) u_classify (
    .en       (acc_en),
    .per_sel  (per_sel),
    .gran_idx (acc_addr[ADDR_W-1:GRAN_W]),
    .bound    (part_bound),
    .is_prog  (cls_is_prog),
    .route    (cls_route)
  );

  assign sram_sel = (cls_route == RT_SRAM);
  assign pe_hit   = (cls_route == RT_PERIPH);

  bwm_sram_map #(.NUM_CE(NUM_CE), .HI_W(HI_W)) u_sram_map (
    .sel     (sram_sel),
    .wide    (msel_wide),
    .hi_addr (acc_addr[ADDR_W-1:BLK_W]),
    .ce_n    (ce_map_n)
  );

  bwm_pe_map #(.NUM_PE(NUM_PE), .PSEL_W(PSEL_W)) u_pe_map (
    .hit  (pe_hit),
    .slot (acc_addr[PE_W+PSEL_W-1:PE_W]),
    .pe_n (pe_map_n)
  );

  bwm_pf_gate #(.N(NUM_CE), .MASK(CE_PF_MASK)) u_ce_gate (
    .pf    (pwr_fail),
    .in_n  (ce_map_n),
    .out_n (ce_nxt_n)
  );

  bwm_pf_gate #(.N(NUM_PE), .MASK(PE_PF_MASK)) u_pe_gate (
    .pf    (pwr_fail),
    .in_n  (pe_map_n),
    .out_n (pe_nxt_n)
  );

  assign wr_nxt_n = !(acc_wr && !cls_is_prog);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_n <= '1;
      pe_n <= '1;
      wr_n <= 1'b1;
      ba   <= '0;
    end else if (acc_en) begin
      ce_n <= ce_nxt_n;
      pe_n <= pe_nxt_n;
      wr_n <= wr_nxt_n;
      ba   <= acc_addr[BLK_W-1:0];
    end else begin
      ce_n <= '1;
      pe_n <= '1;
      wr_n <= 1'b1;
    end
  end

endmodule

// File: rtl/bwmem_decoder_chk.sv
module bwmem_decoder_chk #(
  parameter int ADDR_W = 17,
  parameter int BLK_W  = 15,
  parameter int NUM_CE = 4,
  parameter int NUM_PE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              per_sel,
  input logic              msel_wide,
  input logic              pwr_fail,
  input logic              is_prog,
  input logic [BLK_W-1:0]  ba,
  input logic [NUM_CE-1:0] ce_n,
  input logic [NUM_PE-1:0] pe_n,
  input logic              wr_n
);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> (&ce_n && &pe_n && wr_n));

  p_parked_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !msel_wide) |=> ce_n[NUM_CE-1]);

  p_periph_no_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && per_sel && !is_prog) |=> &ce_n);

  p_no_periph_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !per_sel) |=> &pe_n);

  p_wprot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && is_prog) |=> wr_n);

  p_read_no_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr) |=> wr_n);

  p_pf_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && pwr_fail) |=> (&ce_n && &pe_n[1:0]));

  p_single_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && msel_wide) |=> ($countones(~ce_n) + $countones(~pe_n) <= 1));

  p_single_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !msel_wide) |=> ($countones({~ce_n[0], ~pe_n}) <= 1));

  p_bus_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> (ba == $past(acc_addr[BLK_W-1:0])));

endmodule

bind bwmem_decoder bwmem_decoder_chk #(
  .ADDR_W (ADDR_W),
  .BLK_W  (BLK_W),
  .NUM_CE (NUM_CE),
  .NUM_PE (NUM_PE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .per_sel   (per_sel),
  .msel_wide (msel_wide),
  .pwr_fail  (pwr_fail),
  .is_prog   (cls_is_prog),
  .ba        (ba),
  .ce_n      (ce_n),
  .pe_n      (pe_n),
  .wr_n      (wr_n)
);

// File: tb/bwmem_decoder_tb_top.sv
module bwmem_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  typedef struct packed {
    logic [3:0]  req;
    logic        msel;
    logic        per;
    logic        pf;
    logic        wr;
    logic [6:0]  bound;
    logic [16:0] addr;
    logic [3:0]  ce;
    logic [3:0]  pe;
    logic        w;
  } vec_t;

  // req, msel, per, pf, wr, bound, addr, expected ce_n, pe_n, wr_n
  localparam vec_t VEC [NV] = '{
    '{4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  17'h00010, 4'b1110, 4'b1111, 1'b1}, // R2 block 0
    '{4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  17'h08000, 4'b1101, 4'b1111, 1'b1}, // R2 block 1
    '{4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  17'h10000, 4'b1011, 4'b1111, 1'b1}, // R2 block 2
    '{4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  17'h1FFFF, 4'b0111, 4'b1111, 1'b1}, // R2 block 3
    '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0,  17'h18000, 4'b1110, 4'b1111, 1'b1}, // R3 A16=1 A15=1
    '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0,  17'h08000, 4'b1100, 4'b1111, 1'b1}, // R3 A16=0 A15=1
    '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0,  17'h10000, 4'b1010, 4'b1111, 1'b1}, // R3 A16=1 A15=0
    '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0,  17'h00000, 4'b1000, 4'b1111, 1'b1}, // R3 A16=0 A15=0
    '{4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 7'd0,  17'h04000, 4'b1111, 4'b1101, 1'b1}, // R4 slot 1
    '{4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 7'd0,  17'h1C000, 4'b1111, 4'b0111, 1'b1}, // R4 slot 3, bit 16 ignored
    '{4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 7'd16, 17'h04000, 4'b1110, 4'b1111, 1'b1}, // R5 program stays in memory
    '{4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 7'd16, 17'h08000, 4'b1111, 4'b1011, 1'b1}, // R4 slot 2 above boundary
    '{4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 7'd0,  17'h0C000, 4'b1111, 4'b0111, 1'b1}, // R4 narrow strap, CEs high
    '{4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0,  17'h04000, 4'b1110, 4'b1111, 1'b1}, // R5 no peripheral
    '{4'd6, 1'b1, 1'b0, 1'b0, 1'b1, 7'd16, 17'h07FFF, 4'b1110, 4'b1111, 1'b1}, // R6 last program byte
    '{4'd6, 1'b1, 1'b0, 1'b0, 1'b1, 7'd16, 17'h08000, 4'b1101, 4'b1111, 1'b0}, // R6 first data byte
    '{4'd7, 1'b1, 1'b0, 1'b1, 1'b0, 7'd0,  17'h00000, 4'b1111, 4'b1111, 1'b1}, // R7 CE gated
    '{4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 7'd0,  17'h18000, 4'b1111, 4'b1111, 1'b1}, // R7 narrow gated
    '{4'd7, 1'b1, 1'b1, 1'b1, 1'b0, 7'd0,  17'h00000, 4'b1111, 4'b1111, 1'b1}, // R7 PE1 gated
    '{4'd7, 1'b1, 1'b1, 1'b1, 1'b0, 7'd0,  17'h08000, 4'b1111, 4'b1011, 1'b1}, // R7 PE3 not gated
    '{4'd7, 1'b1, 1'b1, 1'b1, 1'b0, 7'd0,  17'h0C000, 4'b1111, 4'b0111, 1'b1}, // R7 PE4 not gated
    '{4'd10, 1'b1, 1'b1, 1'b0, 1'b1, 7'd64, 17'h1FFFF, 4'b0111, 4'b1111, 1'b1}, // R10 all program
    '{4'd10, 1'b1, 1'b0, 1'b0, 1'b1, 7'd0,  17'h00000, 4'b1110, 4'b1111, 1'b0}  // R10 all data
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en;
  logic        acc_wr;
  logic [16:0] acc_addr;
  logic [6:0]  part_bound;
  logic        per_sel;
  logic        msel_wide;
  logic        pwr_fail;
  logic [14:0] ba;
  logic [3:0]  ce_n;
  logic [3:0]  pe_n;
  logic        wr_n;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bwmem_decoder dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .part_bound (part_bound),
    .per_sel    (per_sel),
    .msel_wide  (msel_wide),
    .pwr_fail   (pwr_fail),
    .ba         (ba),
    .ce_n       (ce_n),
    .pe_n       (pe_n),
    .wr_n       (wr_n)
  );

  task automatic chk(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle_check(input string what);
    chk(1, {what, " ce_n"}, 32'(ce_n), 32'hF);
    chk(1, {what, " pe_n"}, 32'(pe_n), 32'hF);
    chk(1, {what, " wr_n"}, 32'(wr_n), 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_addr = '0;
    part_bound = '0; per_sel = 1'b0; msel_wide = 1'b1; pwr_fail = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    idle_check("reset");
    chk(1, "reset ba", 32'(ba), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("idle after reset"); // R1

    for (int i = 0; i < NV; i++) begin
      msel_wide  = VEC[i].msel;
      per_sel    = VEC[i].per;
      pwr_fail   = VEC[i].pf;
      acc_wr     = VEC[i].wr;
      part_bound = VEC[i].bound;
      acc_addr   = VEC[i].addr;
      acc_en     = 1'b1;
      @(negedge clk);
      chk(int'(VEC[i].req), $sformatf("vec %0d ce_n", i), 32'(ce_n), 32'(VEC[i].ce));
      chk(int'(VEC[i].req), $sformatf("vec %0d pe_n", i), 32'(pe_n), 32'(VEC[i].pe));
      chk(int'(VEC[i].req), $sformatf("vec %0d wr_n", i), 32'(wr_n), 32'(VEC[i].w));
      // R9: bus address follows the low 15 address bits
      chk(9, $sformatf("vec %0d ba", i), 32'(ba), 32'(VEC[i].addr[14:0]));
      // R8: count of asserted enables
      if (VEC[i].msel)
        chk(8, $sformatf("vec %0d enables low", i),
            32'($countones(~ce_n) + $countones(~pe_n)) <= 1 ? 32'h1 : 32'h0, 32'h1);
      else
        chk(8, $sformatf("vec %0d enables low", i),
            32'($countones({~ce_n[0], ~pe_n})) <= 1 ? 32'h1 : 32'h0, 32'h1);
    end

    // R1: strobe dropped, outputs return high one edge later
    acc_en = 1'b0;
    @(negedge clk);
    idle_check("strobe low");

    // R1: address changes with strobe low have no effect
    acc_addr = 17'h08000; msel_wide = 1'b1; per_sel = 1'b0; pwr_fail = 1'b0;
    acc_wr = 1'b1; part_bound = 7'd0;
    @(negedge clk);
    idle_check("addr change idle");

    // R9: result not visible before the sampling edge, visible after it
    acc_en = 1'b1; acc_wr = 1'b0;
    #(CLK_PERIOD/4);
    chk(9, "before edge ce_n", 32'(ce_n), 32'hF);
    @(negedge clk);
    chk(9, "after edge ce_n", 32'(ce_n), 32'hD);
    acc_en = 1'b0;
    @(negedge clk);
    idle_check("final idle");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule